// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Status Queue

This block receives asynchronous serial characters on a single line and delivers them through a small queue. A 16x oversampling tick, produced elsewhere, paces a frame state machine. The machine confirms a start bit at its centre, samples 5 to 8 data bits least significant first, then an optional parity bit and one or two stop bits. Each finished character is written into a 16-entry queue. Every entry carries its own four status flags, so software reads the error state of exactly the character it pops.

Errors are recorded per character: parity mismatch, low stop bit, line break and lost characters. When the queue is full, an arriving character is dropped. The loss is then reported on the next character that is stored. Clearing the enable only stops new frames from starting, so a character already in progress is still completed and stored.

The frame state machine has seven states. IDLE moves to START_CHK on a tick that sees the line low while enabled. START_CHK moves to DATA_BITS if the line is still low at the eighth tick, and otherwise returns to IDLE (glitch). DATA_BITS moves to PARITY_BIT after the last data bit when parity is on, and to STOP_1 when it is off. PARITY_BIT moves to STOP_1. STOP_1 moves in one of three ways: to BREAK_WAIT (and stores) on a break; to STOP_2 when two stop bits are set; otherwise to IDLE (and stores). STOP_2 moves to IDLE (and stores). BREAK_WAIT moves to IDLE once the line is high.

Top module: `serial_rx_tagged`

## Requirements
- R1: A low pulse on the line that is gone by the eighth tick after it is first seen is ignored, and no character is stored.
- R2: Data bits are taken least significant first. The length code `cfg_len` gives the number of data bits: 0→5, 1→6, 2→7, 3→8. Unused upper bits of `rd_data` read 0.
- R3: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. A mismatch sets `rd_flags[1]`.
- R4: A low first stop bit sets the framing flag `rd_flags[0]`. `cfg_stop2`=1 makes the receiver wait out a second stop bit before accepting a new start.
- R5: A break is a frame in which every data bit, the parity bit (if enabled) and the first stop bit are low. It stores one entry with data 0, `rd_flags[2]`=1, `rd_flags[0]`=1 and `rd_flags[1]`=0. No further character is accepted until the line returns high.
- R6: The queue holds 16 entries and returns them in arrival order. `rd_data`/`rd_flags` show the oldest entry. `rd_en` pops one entry when the queue is not empty. `fifo_full` and `fifo_empty` report the queue state.
- R7: A character completed while the queue is full is discarded. The next character that is stored has the overrun flag `rd_flags[3]` set.
- R8: Reception is enabled after reset. With `rx_en`=0 no new frame starts, but a frame already in progress is completed and stored.
- R9: After reset the queue is empty (`fifo_empty`=1, `fifo_full`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_line | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Allows new frames to start |
| cfg_len | input | 2 | Data length code (0..3 → 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Two stop bits |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_flags | output | 4 | {overrun, break, parity, framing} of the oldest entry |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue holds 16 entries |

## Verification
The assertions assume that the configuration inputs stay fixed while a frame is being received. They also assume that the line is driven with whole bit times of 16 ticks. The bench follows both rules: it changes configuration only between frames, and it holds each bit for 16 clocks with one tick per clock. A framing-error stop bit is held low only long enough to cover its centre sample, so that the trailing low level cannot look like a new start. The bench pops entries only between frames, so a pop never coincides with a store.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        IDLE, START_CHK, DATA_BITS, PARITY_BIT, STOP_1, STOP_2, BREAK_WAIT
    } rx_state_e;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } rx_flags_t;

    localparam int unsigned CHAR_W = 8;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              en,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    output logic              push,
    output logic [CHAR_W-1:0] push_data,
    output logic              push_frm,
    output logic              push_par,
    output logic              push_brk,
    output logic              busy
);
    localparam int unsigned CW   = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [2:0]        bit_q, bit_d;
    logic [CHAR_W-1:0] sh_q, sh_d;
    logic              acc_q, acc_d;
    logic              ones_q, ones_d;
    logic              perr_q, perr_d;
    logic              frm_q, frm_d;
    logic              brk_q, brk_d;
    logic              push_q, push_d;

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            acc_q   <= 1'b0;
            ones_q  <= 1'b0;
            perr_q  <= 1'b0;
            frm_q   <= 1'b0;
            brk_q   <= 1'b0;
            push_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            acc_q   <= acc_d;
            ones_q  <= ones_d;
            perr_q  <= perr_d;
            frm_q   <= frm_d;
            brk_q   <= brk_d;
            push_q  <= push_d;
        end
    end

    logic at_mid, at_last;
    assign at_mid  = tick && (cnt_q == MID);
    assign at_last = tick && (cnt_q == LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = tick ? cnt_q + 1'b1 : cnt_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        acc_d   = acc_q;
        ones_d  = ones_q;
        perr_d  = perr_q;
        frm_d   = frm_q;
        brk_d   = brk_q;
        push_d  = 1'b0;
        unique case (state_q)
            IDLE: begin
                cnt_d = '0;
                if (tick && en && !line) state_d = START_CHK;
            end
            START_CHK: begin
                if (at_mid) begin
                    cnt_d = '0;
                    if (!line) begin
                        state_d = DATA_BITS;
                        bit_d   = '0;
                        acc_d   = 1'b0;
                        ones_d  = 1'b0;
                        perr_d  = 1'b0;
                        frm_d   = 1'b0;
                        brk_d   = 1'b0;
                    end else begin
                        state_d = IDLE;
                    end
                end
            end
            DATA_BITS: begin
                if (at_last) begin
                    sh_d   = {line, sh_q[CHAR_W-1:1]};
                    acc_d  = acc_q ^ line;
                    ones_d = ones_q | line;
                    bit_d  = bit_q + 1'b1;
                    if (bit_q == {1'b1, cfg_len})
                        state_d = cfg_par_en ? PARITY_BIT : STOP_1;
                end
            end
            PARITY_BIT: begin
                if (at_last) begin
                    perr_d  = acc_q ^ line ^ cfg_par_odd;
                    ones_d  = ones_q | line;
                    state_d = STOP_1;
                end
            end
            STOP_1: begin
                if (at_last) begin
                    frm_d = !line;
                    brk_d = !line && !ones_q;
                    if (!line && !ones_q) begin
                        push_d  = 1'b1;
                        state_d = BREAK_WAIT;
                    end else if (cfg_stop2) begin
                        state_d = STOP_2;
                    end else begin
                        push_d  = 1'b1;
                        state_d = IDLE;
                    end
                end
            end
            STOP_2: begin
                if (at_last) begin
                    push_d  = 1'b1;
                    state_d = IDLE;
                end
            end
            BREAK_WAIT: begin
                if (line) state_d = IDLE;
            end
            default: state_d = IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push     = push_q;
        push_frm = frm_q;
        push_brk = brk_q;
        push_par = perr_q && !brk_q;
        busy     = (state_q != IDLE);
        unique case (cfg_len)
            2'd0:    push_data = sh_q >> 3;
            2'd1:    push_data = sh_q >> 2;
            2'd2:    push_data = sh_q >> 1;
            default: push_data = sh_q;
        endcase
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      cnt_q;
    logic             do_wr, do_rd;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
    import srx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned QUEUE_DEPTH = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_tick,
    input  logic       rx_line,
    input  logic       rx_en,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [3:0] rd_flags,
    output logic       fifo_empty,
    output logic       fifo_full
);
    localparam int unsigned ENTRY_W = CHAR_W + $bits(rx_flags_t);

    logic              line_s;
    logic              push, push_frm, push_par, push_brk, busy;
    logic [CHAR_W-1:0] push_data;
    logic              wr_ok, pend_q;
    rx_flags_t         wflags;
    logic [ENTRY_W-1:0] rentry;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(rx_line), .d_out(line_s)
    );

    srx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .line(line_s), .en(rx_en),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .push(push), .push_data(push_data),
        .push_frm(push_frm), .push_par(push_par), .push_brk(push_brk), .busy(busy)
    );

    assign wr_ok  = push && !fifo_full;
    assign wflags = '{ovr: pend_q, brk: push_brk, par: push_par, frm: push_frm};

    // lost-character marker carried to the next stored entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (push && fifo_full) pend_q <= 1'b1;
        else if (wr_ok)             pend_q <= 1'b0;
    end

    srx_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(push), .wdata({wflags, push_data}),
        .rd(rd_en), .rdata(rentry), .empty(fifo_empty), .full(fifo_full)
    );

    assign rd_data  = rentry[CHAR_W-1:0];
    assign rd_flags = rentry[ENTRY_W-1:CHAR_W];
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_en,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       wr_ok,
    input logic       push,
    input logic       push_brk,
    input logic       push_frm,
    input logic       push_par,
    input logic [7:0] push_data,
    input logic       pend_q,
    input logic       busy
);
    assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_store_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && fifo_empty) |=> !fifo_empty);

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fifo_empty && !push) |=> fifo_empty);

    assert_break_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_brk) |-> (push_data == 8'h00 && push_frm && !push_par));

    assert_drop_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full) |=> pend_q);

    assert_no_start_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !busy) |=> !busy);

    assert_push_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);
endmodule

bind serial_rx_tagged srx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_en(rd_en),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .wr_ok(wr_ok),
    .push(push), .push_brk(push_brk), .push_frm(push_frm), .push_par(push_par),
    .push_data(push_data), .pend_q(pend_q), .busy(busy)
);

// File: tb/serial_rx_tagged_tb.sv
module serial_rx_tagged_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] rd_flags;
    logic       fifo_empty, fifo_full;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [11:0] exp_q[$];

    always #2 clk = ~clk;

    serial_rx_tagged dut_i (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line), .rx_en(rx_en),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_en(rd_en), .rd_data(rd_data), .rd_flags(rd_flags),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] expect_entry(input logic [7:0] d, input logic [1:0] len,
            input logic pe, input logic po, input logic bp, input logic bs, input logic ovr);
        logic [7:0] m;
        logic pbit, brk;
        m    = d & (8'hFF >> (3 - len));
        pbit = (^m) ^ po ^ bp;
        brk  = bs && (m == 8'h00) && !(pe && pbit);
        return {ovr, brk, brk ? 1'b0 : (pe && bp), bs, m};
    endfunction

    task automatic send(input logic [7:0] d, input logic bp, input logic bs);
        rx_line = 1'b0; idle(16);
        for (int i = 0; i < 5 + cfg_len; i++) begin rx_line = d[i]; idle(16); end
        if (cfg_par_en) begin
            rx_line = (^(d & (8'hFF >> (3 - cfg_len)))) ^ cfg_par_odd ^ bp; idle(16);
        end
        if (bs) begin rx_line = 1'b0; idle(11); rx_line = 1'b1; idle(5); end
        else    begin rx_line = 1'b1; idle(16); end
        if (cfg_stop2) begin rx_line = 1'b1; idle(16); end
        rx_line = 1'b1; idle(16);
    endtask

    task automatic pop_check(input string req, input logic [11:0] exp);
        check(req, {rd_flags, rd_data}, exp);
        rd_en = 1'b1; idle(1); rd_en = 1'b0; idle(1);
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) begin
            check({req, " not empty"}, fifo_empty, 1'b0);
            pop_check(req, exp_q.pop_front());
        end
        check({req, " empty after drain"}, fifo_empty, 1'b1);
    endtask

    initial begin
        logic [7:0] d;
        logic bp, bs;
        void'($urandom(32'h5EED_1234));
        idle(3);
        // R9: reset state
        check("R9 empty at reset", fifo_empty, 1'b1);
        check("R9 full at reset", fifo_full, 1'b0);
        rst_n = 1'b1; idle(4);

        // R8 enabled out of reset, R2 8-bit LSB first
        send(8'hA5, 1'b0, 1'b0);
        exp_q.push_back(expect_entry(8'hA5, 2'd3, 0, 0, 0, 0, 0));
        drain("R2 R8 basic frame");

        // R1: short glitch ignored
        rx_line = 1'b0; idle(5); rx_line = 1'b1; idle(40);
        check("R1 glitch stored nothing", fifo_empty, 1'b1);

        // R2 5-bit: upper bits of the pattern must not appear
        cfg_len = 2'd0;
        send(8'hFF, 1'b0, 1'b0);
        exp_q.push_back(expect_entry(8'hFF, 2'd0, 0, 0, 0, 0, 0));
        drain("R2 five-bit frame");

        // R3 odd parity, good and bad
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        send(8'h3C, 1'b0, 1'b0); exp_q.push_back(expect_entry(8'h3C, 3, 1, 1, 0, 0, 0));
        send(8'h3C, 1'b1, 1'b0); exp_q.push_back(expect_entry(8'h3C, 3, 1, 1, 1, 0, 0));
        drain("R3 odd parity");

        // R4 framing with two stop bits
        cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
        send(8'h81, 1'b0, 1'b1); exp_q.push_back(expect_entry(8'h81, 3, 0, 0, 0, 1, 0));
        send(8'h18, 1'b0, 1'b0); exp_q.push_back(expect_entry(8'h18, 3, 0, 0, 0, 0, 0));
        drain("R4 stop check");
        cfg_stop2 = 1'b0;

        // R5 break: long low, single entry, then normal frame
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        rx_line = 1'b0; idle(16 * 25); rx_line = 1'b1; idle(32);
        exp_q.push_back(12'h500);
        send(8'h42, 1'b0, 1'b0); exp_q.push_back(expect_entry(8'h42, 3, 1, 0, 0, 0, 0));
        drain("R5 break");
        cfg_par_en = 1'b0;

        // R8 disable during a frame: frame still stored
        fork
            send(8'h5A, 1'b0, 1'b0);
            begin idle(48); rx_en = 1'b0; end
        join
        exp_q.push_back(expect_entry(8'h5A, 3, 0, 0, 0, 0, 0));
        drain("R8 frame finishes after disable");
        send(8'h77, 1'b0, 1'b0);
        check("R8 disabled ignores frame", fifo_empty, 1'b1);
        rx_en = 1'b1;

        // R6/R7 fill, overrun, pop, next entry tagged
        for (int i = 0; i < 16; i++) begin
            send(8'(i + 8'h10), 1'b0, 1'b0);
            exp_q.push_back(expect_entry(8'(i + 8'h10), 3, 0, 0, 0, 0, 0));
        end
        check("R6 full after 16", fifo_full, 1'b1);
        send(8'hEE, 1'b0, 1'b0);
        check("R7 still full after drop", fifo_full, 1'b1);
        pop_check("R6 oldest first", exp_q.pop_front());
        check("R6 not full after pop", fifo_full, 1'b0);
        send(8'hC3, 1'b0, 1'b0);
        exp_q.push_back(expect_entry(8'hC3, 3, 0, 0, 0, 0, 1));
        drain("R7 overrun tag");

        // random mix covering R2 R3 R4 R5
        for (int n = 0; n < 60; n++) begin
            cfg_len     = 2'($urandom_range(0, 3));
            cfg_par_en  = 1'($urandom_range(0, 1));
            cfg_par_odd = 1'($urandom_range(0, 1));
            cfg_stop2   = 1'($urandom_range(0, 1));
            d  = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom);
            bp = cfg_par_en && ($urandom_range(0, 3) == 0);
            bs = ($urandom_range(0, 4) == 0);
            send(d, bp, bs);
            exp_q.push_back(expect_entry(d, cfg_len, cfg_par_en, cfg_par_odd, bp, bs, 0));
            if (exp_q.size() >= 10) drain("R2 R3 R4 R5 random");
        end
        drain("R2 R3 R4 R5 random");
        finish_run();
    end
endmodule